// File: doc/BRIEF.md
# Nibble-Serial 64-Bit Block Cipher Encryptor

This block is a compact encryption engine for the 64-bit substitution-permutation cipher with an 80-bit key (the PRESENT-80 algorithm). It does not give each round a full-width datapath. The state sits in a shift register of sixteen 4-bit nibbles, and each clock moves one nibble through a single shared 4-bit substitution box, after the matching round-key nibble has been XORed into it. A round therefore takes sixteen substitution cycles and then one cycle that applies the 64-bit bit permutation. The key schedule advances in that same permutation cycle, and it borrows the shared S-box for its own nibble substitution.

The user places a plaintext and a key on the inputs and pulses the start strobe while the core is idle. The core samples both inputs on that edge and runs 31 rounds. It then XORs the last round key into the state and presents the result on the ciphertext output, with a one-cycle done pulse. The ciphertext stays on the output until the next encryption completes. A start strobe that arrives while the core is busy has no effect.

Top module: `present_nibble_core`

## Requirements
- R1: On an edge with start_i high and the core idle, the core samples plaintext_i and key_i. done_o then goes high exactly 528 clock cycles later: 31 rounds of 17 cycles each, plus one output cycle.
- R2: ciphertext_o equals the PRESENT-80 encryption of the sampled plaintext under the sampled key. Examples (key, plaintext → ciphertext): (0, 0 → 5579C1387B228445), (all ones, 0 → E72C46C0F5945049), (0, all ones → A112FFC72F68417B), (all ones, all ones → 3333DCD3213210D2).
- R3: The single substitution box maps input values 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. It serves every state nibble and the key-schedule nibble.
- R4: After the sixteen substitution cycles of a round, the state bit at position i moves to position 16*i mod 63 for i < 63, and bit 63 stays in place.
- R5: The 80-bit key register is loaded from key_i on start. Once per round it is updated as follows:
  - rotate it left by 61;
  - substitute bits 79..76 through the S-box;
  - XOR the round number (1..31) into bits 19..15.
  
  The round key is bits 79..16.
- R6: done_o is high for exactly one cycle per completed encryption.
- R7: A start_i pulse, or a change of plaintext_i or key_i, during a running encryption changes neither the result nor its completion time.
- R8: Synchronous active-low reset clears done_o and ciphertext_o to zero and abandons any running encryption, so no done pulse follows. Outside a done pulse, ciphertext_o holds its value.
- R9: A start_i sampled on the edge directly after a done pulse is accepted, which allows back-to-back encryptions.
- R10: A round is made of sixteen one-nibble substitution cycles and then one permutation cycle. The round in which the round number reaches 31 is followed by the final key XOR and no further round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, honoured only when idle |
| plaintext_i | input | 64 | Plaintext block, sampled on an accepted start |
| key_i | input | 80 | Cipher key, sampled on an accepted start |
| ciphertext_o | output | 64 | Result of the last completed encryption |
| done_o | output | 1 | One-cycle pulse when ciphertext_o is updated |

## Verification
The assertions take for granted that reset is held low across at least one rising edge before the core is used. The output hold check depends on that edge, since it compares against the value the reset edge cleared. The assertions place no requirement on when start_i arrives, because the core must tolerate a start at any time. The stimulus nonetheless changes start_i and the data inputs only at falling edges, and it also drives starts and new inputs in the middle of a run and directly after a done pulse. This exercises the busy-ignore and back-to-back paths against their assertions.

// File: rtl/present_nib_pkg.sv
// Shared definitions for the nibble-serial cipher core.
// Assumes: one nibble is 4 bits and the key schedule rotates by 61.
package present_nib_pkg;

    // Sequencer phase of the core.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SUB   = 2'd1,
        PH_PERM  = 2'd2,
        PH_FINAL = 2'd3
    } phase_t;

    localparam int NIB_W_DEF   = 4;
    localparam int STATE_W_DEF = 64;
    localparam int KEY_W_DEF   = 80;
    localparam int ROUNDS_DEF  = 31;
    localparam int KEY_ROT_DEF = 61;
    localparam int RC_LSB_DEF  = 15;

endpackage

// File: rtl/present_nib_sbox.sv
// 4-bit substitution box, purely combinational (R3).
// Assumes: exactly one instance exists in the core; the caller multiplexes
// the state path and the key-schedule path onto it.
module present_nib_sbox (
    input  logic [3:0] x_i,
    output logic [3:0] y_o
);

    // Substitution table lookup.
    always_comb begin
        unique case (x_i)
            4'h0: y_o = 4'hC;
            4'h1: y_o = 4'h5;
            4'h2: y_o = 4'h6;
            4'h3: y_o = 4'hB;
            4'h4: y_o = 4'h9;
            4'h5: y_o = 4'h0;
            4'h6: y_o = 4'hA;
            4'h7: y_o = 4'hD;
            4'h8: y_o = 4'h3;
            4'h9: y_o = 4'hE;
            4'hA: y_o = 4'hF;
            4'hB: y_o = 4'h8;
            4'hC: y_o = 4'h4;
            4'hD: y_o = 4'h7;
            4'hE: y_o = 4'h1;
            default: y_o = 4'h2;
        endcase
    end

endmodule

// File: rtl/present_nib_perm.sv
// Full-width bit permutation layer, pure wiring (R4).
// Bit i goes to (i * GROUPS) mod (W-1); the top bit stays put.
// Assumes: W = GROUPS * (W / GROUPS), so the mapping is a bijection.
module present_nib_perm #(
    parameter int W      = 64,
    parameter int GROUPS = 16
) (
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);

    localparam int MODV = W - 1;

    for (genvar g = 0; g < W; g++) begin : g_bit
        localparam int DST = (g == W - 1) ? g : ((g * GROUPS) % MODV);
        assign d_o[DST] = d_i[g];
    end

endmodule

// File: rtl/present_nib_keysched.sv
// 80-bit key register with the per-round update (R5).
// The update sends the rotated top nibble out through sbox_x_o and
// takes its substitution back on sbox_y_i, because the core has only
// one S-box.
// Assumes: update_i and load_i are never high together.
module present_nib_keysched #(
    parameter int KEY_W  = 80,
    parameter int RK_W   = 64,
    parameter int NIB_W  = 4,
    parameter int RC_W   = 5,
    parameter int ROT    = 61,
    parameter int RC_LSB = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              update_i,
    input  logic [RC_W-1:0]   round_i,
    input  logic [NIB_W-1:0]  sbox_y_i,
    output logic [NIB_W-1:0]  sbox_x_o,
    output logic [RK_W-1:0]   round_key_o
);

    localparam int LO_W = KEY_W - ROT;

    logic [KEY_W-1:0] key_q;
    logic [KEY_W-1:0] key_rot;
    logic [KEY_W-1:0] key_upd;

    // Rotate left by ROT positions.
    assign key_rot  = {key_q[LO_W-1:0], key_q[KEY_W-1:LO_W]};
    assign sbox_x_o = key_rot[KEY_W-1 -: NIB_W];

    // Apply the substituted top nibble and the round-number XOR.
    always_comb begin
        key_upd = key_rot;
        key_upd[KEY_W-1 -: NIB_W] = sbox_y_i;
        key_upd[RC_LSB +: RC_W]   = key_rot[RC_LSB +: RC_W] ^ round_i;
    end

    // Key register: load on start, advance once per round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (load_i) begin
            key_q <= key_i;
        end else if (update_i) begin
            key_q <= key_upd;
        end
    end

    assign round_key_o = key_q[KEY_W-1 -: RK_W];

    assert_key_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (round_key_o == $past(key_i[KEY_W-1 -: RK_W])));

    assert_key_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !update_i) |=> $stable(key_q));

endmodule

// File: rtl/present_nibble_core.sv
// Nibble-serial encryptor for the 64-bit / 80-bit-key SPN cipher.
// Each round has sixteen cycles that take the low state nibble, XOR in
// the matching round-key nibble, substitute it and shift it in at the
// top. After sixteen shifts every nibble is back in its own slot. A
// seventeenth cycle then permutes the full state and advances the key.
// Assumes: start_i, plaintext_i and key_i are synchronous to clk; the
// data inputs are needed only on the edge that accepts start.
module present_nibble_core
    import present_nib_pkg::*;
#(
    parameter int STATE_W = STATE_W_DEF,
    parameter int KEY_W   = KEY_W_DEF,
    parameter int NIB_W   = NIB_W_DEF,
    parameter int ROUNDS  = ROUNDS_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [STATE_W-1:0] plaintext_i,
    input  logic [KEY_W-1:0]   key_i,
    output logic [STATE_W-1:0] ciphertext_o,
    output logic               done_o
);

    localparam int NIBBLES = STATE_W / NIB_W;
    localparam int CNT_W   = $clog2(NIBBLES);
    localparam int RC_W    = $clog2(ROUNDS + 1);
    localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(NIBBLES - 1);
    localparam logic [RC_W-1:0]  LAST_RND = RC_W'(ROUNDS);

    phase_t             phase_q;
    logic [CNT_W-1:0]   nib_q;
    logic [RC_W-1:0]    round_q;
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_perm;
    logic [STATE_W-1:0] round_key;
    logic [STATE_W-1:0] ct_q;
    logic               done_q;
    logic [NIB_W-1:0]   rk_nib [NIBBLES];
    logic [NIB_W-1:0]   key_sb_x;
    logic [NIB_W-1:0]   sb_x;
    logic [NIB_W-1:0]   sb_y;
    logic               accept;

    assign accept = (phase_q == PH_IDLE) && start_i;

    // Slice the round key into addressable nibbles.
    for (genvar g = 0; g < NIBBLES; g++) begin : g_rk
        assign rk_nib[g] = round_key[g*NIB_W +: NIB_W];
    end

    // Shared S-box input: key nibble in the permutation cycle, else state.
    assign sb_x = (phase_q == PH_PERM) ? key_sb_x
                                       : (state_q[NIB_W-1:0] ^ rk_nib[nib_q]);

    present_nib_sbox u_sbox (
        .x_i (sb_x),
        .y_o (sb_y)
    );

    present_nib_perm #(
        .W      (STATE_W),
        .GROUPS (NIBBLES)
    ) u_perm (
        .d_i (state_q),
        .d_o (state_perm)
    );

    present_nib_keysched #(
        .KEY_W  (KEY_W),
        .RK_W   (STATE_W),
        .NIB_W  (NIB_W),
        .RC_W   (RC_W),
        .ROT    (KEY_ROT_DEF),
        .RC_LSB (RC_LSB_DEF)
    ) u_keys (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .key_i       (key_i),
        .update_i    (phase_q == PH_PERM),
        .round_i     (round_q),
        .sbox_y_i    (sb_y),
        .sbox_x_o    (key_sb_x),
        .round_key_o (round_key)
    );

    // Sequencer: phase, nibble counter and round counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            nib_q   <= '0;
            round_q <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_SUB;
                        nib_q   <= '0;
                        round_q <= RC_W'(1);
                    end
                end
                PH_SUB: begin
                    nib_q <= nib_q + 1'b1;
                    if (nib_q == LAST_NIB) begin
                        phase_q <= PH_PERM;
                    end
                end
                PH_PERM: begin
                    if (round_q == LAST_RND) begin
                        phase_q <= PH_FINAL;
                    end else begin
                        round_q <= round_q + 1'b1;
                        phase_q <= PH_SUB;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // State shift register: load, nibble substitution, permutation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (accept) begin
            state_q <= plaintext_i;
        end else if (phase_q == PH_SUB) begin
            state_q <= {sb_y, state_q[STATE_W-1:NIB_W]};
        end else if (phase_q == PH_PERM) begin
            state_q <= state_perm;
        end
    end

    // Output stage: final key XOR and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_FINAL);
            if (phase_q == PH_FINAL) begin
                ct_q <= state_q ^ round_key;
            end
        end
    end

    assign ciphertext_o = ct_q;
    assign done_o       = done_q;

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ct_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ciphertext_o));

    assert_busy_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SUB || phase_q == PH_PERM) |=> (phase_q != PH_IDLE));

    assert_perm_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SUB && nib_q == LAST_NIB) |=> (phase_q == PH_PERM));

    assert_last_round_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PERM && round_q == LAST_RND) |=> (phase_q == PH_FINAL));

    assert_round_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SUB) |=> (round_q == $past(round_q)));

    assert_done_after_final_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FINAL) |=> done_o);

endmodule

// File: tb/present_nibble_core_tb_top.sv
module present_nibble_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] plaintext_i = '0;
    logic [79:0] key_i = '0;
    logic [63:0] ciphertext_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;

    localparam int LATENCY = 528;
    localparam int NVEC = 4;
    // {key, plaintext, expected ciphertext}
    localparam logic [207:0] VECS [NVEC] = '{
        {80'h0,                    64'h0,                 64'h5579C1387B228445},
        {80'hFFFFFFFFFFFFFFFFFFFF, 64'h0,                 64'hE72C46C0F5945049},
        {80'h0,                    64'hFFFFFFFFFFFFFFFF,  64'hA112FFC72F68417B},
        {80'hFFFFFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF,  64'h3333DCD3213210D2}
    };

    always #5 clk = ~clk;

    present_nibble_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .plaintext_i  (plaintext_i),
        .key_i        (key_i),
        .ciphertext_o (ciphertext_o),
        .done_o       (done_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge where done_o is seen.
    task automatic run_enc(input logic [79:0] k, input logic [63:0] p, output int n);
        key_i = k;
        plaintext_i = p;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset done", 64'(done_o), 64'd0);
        check("R8 reset ciphertext", ciphertext_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3/R4/R5: vector table
        for (int i = 0; i < NVEC; i++) begin
            run_enc(VECS[i][207:128], VECS[i][127:64], n);
            check("R2/R3/R4/R5 ciphertext", ciphertext_o, VECS[i][63:0]);
            check("R1/R10 latency", 64'(n), 64'(LATENCY));
            @(negedge clk);
        end

        // R6: done is a single-cycle pulse
        run_enc(VECS[1][207:128], VECS[1][127:64], n);
        @(negedge clk);
        check("R6 done pulse width", 64'(done_o), 64'd0);

        // R8: ciphertext holds after done
        held = ciphertext_o;
        repeat (20) @(negedge clk);
        check("R8 ciphertext hold", ciphertext_o, held);

        // R7: start and new data during a run are ignored
        key_i = VECS[0][207:128];
        plaintext_i = VECS[0][127:64];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (100) @(negedge clk);
        key_i = VECS[3][207:128];
        plaintext_i = VECS[3][127:64];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 101;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R7 busy start ignored ciphertext", ciphertext_o, VECS[0][63:0]);
        check("R7 busy start ignored latency", 64'(n), 64'(LATENCY));

        // R9: back-to-back start on the done cycle
        run_enc(VECS[2][207:128], VECS[2][127:64], n);
        check("R9 first run ciphertext", ciphertext_o, VECS[2][63:0]);
        run_enc(VECS[3][207:128], VECS[3][127:64], n);
        check("R9 back-to-back ciphertext", ciphertext_o, VECS[3][63:0]);
        check("R9 back-to-back latency", 64'(n), 64'(LATENCY));
        @(negedge clk);

        // R8: reset mid-run abandons the encryption
        key_i = VECS[1][207:128];
        plaintext_i = VECS[1][127:64];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 mid-run reset done", 64'(done_o), 64'd0);
        check("R8 mid-run reset ciphertext", ciphertext_o, 64'd0);
        rst_n = 1'b1;
        n = 0;
        for (int c = 0; c < 700; c++) begin
            @(negedge clk);
            if (done_o) n++;
        end
        check("R8 no done after reset", 64'(n), 64'd0);

        // R2: recovery after reset
        run_enc(VECS[1][207:128], VECS[1][127:64], n);
        check("R2 after reset ciphertext", ciphertext_o, VECS[1][63:0]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule